// File: doc/BRIEF.md
# Clock Frequency Select and Output Gating Controller

This block is the control layer of a multi-output clock generator. It picks the 4-bit frequency code that steers the synthesizer. The code comes either from strap pins or from software register bits. The block also forwards the spread-spectrum controls and the global output-enable, and it gates each of 25 derived clocks on and off without producing partial pulses. The strap pins double as clock outputs on the package, so their levels are captured during a short window after reset and then frozen.

The register bank lives elsewhere and is presented here as five byte-wide inputs. Only the bits that this block decodes are used. The output clocks arrive as `src_clk_i`. They are derived from the reference clock and change away from its rising edge. They leave as `gclk_o`, where each one runs only while its enable bit and the power-down pin allow it. Whenever the selected code changes, a pending flag stays up for a programmable number of reference cycles, so that the synthesizer has time to settle.

Top module: `clk_sel_ctrl`

## Requirements
- R1: While `reg0_i[3]`=0, `code_o` equals the strap code latched during the window. `sel66_o` equals the latched table-select strap. Both read 0 while reset is asserted.
- R2: Straps are sampled on each of the first STRAP_CYC rising edges after reset release. Later strap changes never reach `code_o` or `sel66_o`.
- R3: While `reg0_i[3]`=1, `code_o` = {`reg0_i[2]`, `reg0_i[6:4]`}, registered one cycle after the inputs.
- R4: While `reg0_i[3]`=1, `sel66_o` follows `reg1_i[1]` with one cycle of latency.
- R5: `ss_en_o` follows `reg0_i[1]`. `ss_down_o` follows `reg0_i[7]`, where 0 selects centre spread and 1 selects down spread.
- R6: `oe_o` is 0 while `reg0_i[0]`=1 and is 1 otherwise.
- R7: The enable bit for `gclk_o[k]` (1 = run) is mapped as follows. Indices 7:0 come from `reg2_i[7:0]` and indices 15:8 come from `reg3_i[7:0]`. The remaining indices are: 16 = `reg1_i[0]`, 17 = `reg4_i[0]`, 18 = `reg4_i[1]`, 19 = `reg4_i[3]`, 20 = `reg4_i[5]`, 21 = `reg4_i[6]`, 22 = `reg1_i[3]`, 23 = `reg1_i[2]`, 24 = `reg1_i[4]`.
- R8: A gate's run state changes only on a rising reference edge at which its source clock is low. `gclk_o[k]` therefore always equals `src_clk_i[k]` ANDed with that state, and it never shows a shortened high phase.
- R9: While `pd_ni`=0, every `gclk_o` stops low at its next low phase. When `pd_ni` returns to 1, outputs resume according to the unchanged register enables.
- R10: A change of the selected code raises `pending_o` for exactly `settle_i` cycles. If `settle_i`=0, or if only `sel66_o` changes, the flag does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Power-down, active low |
| reg0_i | input | 8 | Mode byte: tristate, spread enable, source select, software code, spread type |
| reg1_i | input | 8 | Misc enables and software table select |
| reg2_i | input | 8 | Memory clock enables |
| reg3_i | input | 8 | Bus clock enables |
| reg4_i | input | 8 | CPU, interrupt-controller and 66 MHz clock enables |
| settle_i | input | SET_W | Settle length in reference cycles |
| fs_strap_i | input | 4 | Frequency strap pins |
| sel66_strap_i | input | 1 | Table-select strap pin |
| src_clk_i | input | 25 | Ungated derived clocks |
| code_o | output | 4 | Selected frequency code |
| sel66_o | output | 1 | Selected 66 MHz table select |
| ss_en_o | output | 1 | Spread-spectrum enable |
| ss_down_o | output | 1 | Spread type |
| oe_o | output | 1 | Global output enable (0 = tristate) |
| pending_o | output | 1 | Frequency transition in progress |
| gclk_o | output | 25 | Gated clocks |

## Verification
The strap window is probed at its last edge. A value that first appears on the final sampling edge must be latched, and one that appears a cycle later must not. A window that is off by one in either direction therefore shows up as the wrong code. A walking enable bit across all 25 gates exposes any swapped or dropped enable mapping. A cycle-by-cycle model of the run state, updated only on low phases, catches a gate that switches mid-pulse. The settle counter is checked cycle by cycle, so that a flag one cycle too long or too short, a flag raised by a table-select change alone, or one raised with a zero settle count is reported.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  localparam int FS_W    = 4;
  localparam int NUM_CLK = 25;
  localparam int NUM_SDR = 8;
  localparam int NUM_BUS = 8;
  localparam int IDX_SDR_F = NUM_SDR + NUM_BUS;
  localparam int IDX_CPU0  = IDX_SDR_F + 1;
  localparam int IDX_CPU1  = IDX_SDR_F + 2;
  localparam int IDX_APIC  = IDX_SDR_F + 3;
  localparam int IDX_V66_0 = IDX_SDR_F + 4;
  localparam int IDX_V66_1 = IDX_SDR_F + 5;
  localparam int IDX_U48_0 = IDX_SDR_F + 6;
  localparam int IDX_U48_1 = IDX_SDR_F + 7;
  localparam int IDX_SIO   = IDX_SDR_F + 8;

  typedef struct packed {
    logic [FS_W-1:0] code;
    logic            sel66;
  } freq_sel_t;
endpackage

// File: rtl/clk_strap_latch.sv
module clk_strap_latch #(
  parameter int STRAP_CYC = 8,
  parameter int W         = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] strap_i,
  output logic [W-1:0] latched_o,
  output logic         done_o
);
  localparam int CNT_W = $clog2(STRAP_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STRAP_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      val_q <= '0;
    end else if (cnt_q != LAST) begin
      val_q <= strap_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign latched_o = val_q;
  assign done_o    = (cnt_q == LAST);

  // R2
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($stable(latched_o) && done_o));
endmodule

// File: rtl/clk_code_sel.sv
module clk_code_sel
  import clk_sel_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  freq_sel_t        sel_next_i,
  input  logic [SET_W-1:0] settle_i,
  output freq_sel_t        sel_o,
  output logic             pending_o
);
  freq_sel_t        sel_q;
  logic [SET_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_next_i;
      if (sel_next_i.code != sel_q.code) cnt_q <= settle_i;
      else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sel_o     = sel_q;
  assign pending_o = (cnt_q != '0);

  // R10
  settle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_next_i.code != sel_q.code && settle_i != '0) |=> pending_o);
  // R10
  settle_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_next_i.code == sel_q.code && !pending_o) |=> !pending_o);
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic run_req_i,
  output logic gclk_o
);
  logic run_q;

  // state only moves while the source sits low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 1'b0;
    else if (!src_i) run_q <= run_req_i;
  end

  assign gclk_o = src_i & run_q;

  // R8
  no_runt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i |=> $stable(run_q));
  // R9
  stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_req_i && !src_i) |=> !gclk_o);
endmodule

// File: rtl/clk_sel_ctrl.sv
module clk_sel_ctrl
  import clk_sel_pkg::*;
#(
  parameter int STRAP_CYC = 8,
  parameter int SET_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pd_ni,
  input  logic [7:0]         reg0_i,
  input  logic [7:0]         reg1_i,
  input  logic [7:0]         reg2_i,
  input  logic [7:0]         reg3_i,
  input  logic [7:0]         reg4_i,
  input  logic [SET_W-1:0]   settle_i,
  input  logic [FS_W-1:0]    fs_strap_i,
  input  logic               sel66_strap_i,
  input  logic [NUM_CLK-1:0] src_clk_i,
  output logic [FS_W-1:0]    code_o,
  output logic               sel66_o,
  output logic               ss_en_o,
  output logic               ss_down_o,
  output logic               oe_o,
  output logic               pending_o,
  output logic [NUM_CLK-1:0] gclk_o
);
  localparam int STRAP_W = FS_W + 1;

  logic [STRAP_W-1:0] strap_q;
  logic               strap_done;
  freq_sel_t          sel_next, sel_cur;
  logic [NUM_CLK-1:0] en_vec, run_req;
  logic               sw_mode;
  logic               unused_bits;

  assign unused_bits = ^{reg1_i[7:5], reg4_i[7], reg4_i[4], reg4_i[2]};

  clk_strap_latch #(.STRAP_CYC(STRAP_CYC), .W(STRAP_W)) u_strap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   ({fs_strap_i, sel66_strap_i}),
    .latched_o (strap_q),
    .done_o    (strap_done)
  );

  assign sw_mode = reg0_i[3];

  always_comb begin
    if (sw_mode) begin
      sel_next.code  = {reg0_i[2], reg0_i[6:4]};
      sel_next.sel66 = reg1_i[1];
    end else begin
      sel_next.code  = strap_q[STRAP_W-1:1];
      sel_next.sel66 = strap_q[0];
    end
  end

  clk_code_sel #(.SET_W(SET_W)) u_code (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_next_i (sel_next),
    .settle_i   (settle_i),
    .sel_o      (sel_cur),
    .pending_o  (pending_o)
  );

  assign code_o    = sel_cur.code;
  assign sel66_o   = sel_cur.sel66;
  assign ss_en_o   = reg0_i[1];
  assign ss_down_o = reg0_i[7];
  assign oe_o      = ~reg0_i[0];

  always_comb begin
    en_vec                    = '0;
    en_vec[NUM_SDR-1:0]       = reg2_i;
    en_vec[IDX_SDR_F-1:NUM_SDR] = reg3_i;
    en_vec[IDX_SDR_F]         = reg1_i[0];
    en_vec[IDX_CPU0]          = reg4_i[0];
    en_vec[IDX_CPU1]          = reg4_i[1];
    en_vec[IDX_APIC]          = reg4_i[3];
    en_vec[IDX_V66_0]         = reg4_i[5];
    en_vec[IDX_V66_1]         = reg4_i[6];
    en_vec[IDX_U48_0]         = reg1_i[3];
    en_vec[IDX_U48_1]         = reg1_i[2];
    en_vec[IDX_SIO]           = reg1_i[4];
  end

  assign run_req = en_vec & {NUM_CLK{pd_ni}};

  for (genvar k = 0; k < NUM_CLK; k++) begin : g_gate
    clk_out_gate u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_clk_i[k]),
      .run_req_i (run_req[k]),
      .gclk_o    (gclk_o[k])
    );
  end

  // R3
  sw_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_mode |=> code_o == $past({reg0_i[2], reg0_i[6:4]}));
  // R1
  hw_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_mode && strap_done) |=> code_o == $past(strap_q[STRAP_W-1:1]));
endmodule

// File: tb/tb_clk_sel_ctrl.sv
module tb_clk_sel_ctrl;
  localparam int STRAP_CYC = 4;
  localparam int SET_W     = 8;
  localparam int NC        = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1;
  logic [7:0] reg0 = 8'h00, reg1 = 8'h1f, reg2 = 8'hff, reg3 = 8'hff, reg4 = 8'h6b;
  logic [SET_W-1:0] settle = 8'd3;
  logic [3:0] fs_strap = 4'ha;
  logic sel66_strap = 1'b1;
  logic tog = 1'b0;
  logic [NC-1:0] src, gclk, exp_run, seen;
  logic [3:0] code;
  logic sel66, ss_en, ss_down, oe, pending;
  int n_chk = 0, n_err = 0;
  bit mon_en = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) tog <= ~tog;
  always_comb for (int k = 0; k < NC; k++) src[k] = tog ^ k[0];

  clk_sel_ctrl #(.STRAP_CYC(STRAP_CYC), .SET_W(SET_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n),
    .reg0_i(reg0), .reg1_i(reg1), .reg2_i(reg2), .reg3_i(reg3), .reg4_i(reg4),
    .settle_i(settle), .fs_strap_i(fs_strap), .sel66_strap_i(sel66_strap),
    .src_clk_i(src), .code_o(code), .sel66_o(sel66), .ss_en_o(ss_en),
    .ss_down_o(ss_down), .oe_o(oe), .pending_o(pending), .gclk_o(gclk));

  function automatic logic [NC-1:0] en_map(input logic [7:0] r1, r2, r3, r4);
    return {r1[4], r1[2], r1[3], r4[6], r4[5], r4[3], r4[1], r4[0], r1[0], r3, r2};
  endfunction

  task automatic set_en(input logic [NC-1:0] v);
    reg2 = v[7:0];
    reg3 = v[15:8];
    reg1 = {3'b000, v[24], v[22], v[23], reg1[1], v[16]};
    reg4 = {1'b0, v[21], v[20], 1'b0, v[19], 1'b0, v[18], v[17]};
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic observe(input int n);
    seen = '0;
    repeat (n) begin @(posedge clk); #5; seen |= gclk; end
  endtask

  // reference model of the per-output run state (R8, R9)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_run <= '0;
    else
      for (int k = 0; k < NC; k++)
        if (!src[k]) exp_run[k] <= en_map(reg1, reg2, reg3, reg4)[k] & pd_n;
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && mon_en) chk("R8 gated clock", 32'(gclk), 32'(src & exp_run));
  end

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    #1;
    chk("R1 reset code", 32'(code), 0);
    chk("R1 reset pending", 32'(pending), 0);
    chk("R8 reset outputs", 32'(gclk), 0);
    tick(3);
    rst_n = 1'b1;
    mon_en = 1'b1;
    tick(8);
    chk("R1 strap code", 32'(code), 32'h a);
    chk("R1 strap sel66", 32'(sel66), 1);
    fs_strap = 4'h5; sel66_strap = 1'b0;
    tick(6);
    chk("R2 code held", 32'(code), 32'h a);
    chk("R2 sel66 held", 32'(sel66), 1);

    reg0 = 8'h02; #1;
    chk("R5 spread on", 32'({ss_en, ss_down}), 32'b10);
    reg0 = 8'h80; #1;
    chk("R5 down type", 32'({ss_en, ss_down}), 32'b01);
    reg0 = 8'h01; #1;
    chk("R6 tristate", 32'(oe), 0);
    reg0 = 8'h00; #1;
    chk("R6 running", 32'(oe), 1);
    tick(1);

    // R3 / R4 exhaustive software code and table select
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 2; s++) begin
        reg0 = {1'b0, 3'(c), 1'b1, c[3], 2'b00};
        reg1[1] = s[0];
        tick(1);
        chk("R3 sw code", 32'(code), 32'(c));
        chk("R4 sw sel66", 32'(sel66), 32'(s));
      end

    // R10 settle window
    tick(5);
    settle = 8'd3;
    reg0 = {1'b0, 3'd6, 1'b1, 1'b0, 2'b00};
    tick(1); chk("R10 pending c1", 32'(pending), 1);
    tick(1); chk("R10 pending c2", 32'(pending), 1);
    tick(1); chk("R10 pending c3", 32'(pending), 1);
    tick(1); chk("R10 pending end", 32'(pending), 0);
    settle = 8'd0;
    reg0 = {1'b0, 3'd1, 1'b1, 1'b1, 2'b00};
    tick(1); chk("R10 zero settle", 32'(pending), 0);
    chk("R3 code 9", 32'(code), 9);
    tick(1); chk("R10 zero settle later", 32'(pending), 0);
    settle = 8'd3;
    prev = code;
    reg1[1] = ~reg1[1];
    tick(1);
    chk("R10 sel66 only", 32'(pending), 0);
    chk("R4 sel66 flip", 32'(sel66), 32'(reg1[1]));
    chk("R10 code unchanged", 32'(code), 32'(prev));

    reg0 = 8'h00;
    tick(1);
    chk("R1 back to straps", 32'(code), 32'h a);
    chk("R1 back to strap sel66", 32'(sel66), 1);

    // R2 window edge: value on last sampling edge kept, next one ignored
    mon_en = 1'b0;
    rst_n = 1'b0;
    fs_strap = 4'h3;
    tick(2);
    rst_n = 1'b1;
    mon_en = 1'b1;
    tick(STRAP_CYC - 1);
    fs_strap = 4'h9;
    tick(1);
    fs_strap = 4'h6;
    tick(5);
    chk("R2 last window edge", 32'(code), 9);

    // R7 walking enable across every output
    for (int i = 0; i < NC; i++) begin
      set_en(NC'(1) << i);
      tick(3);
      observe(4);
      chk($sformatf("R7 walk %0d", i), 32'(seen), 32'(NC'(1) << i));
    end
    set_en(25'h0aa_aaaa);
    tick(3); observe(4);
    chk("R7 alternating", 32'(seen), 32'h0aa_aaaa);

    // R9 power-down keeps registers
    set_en('1);
    tick(3);
    pd_n = 1'b0;
    tick(3); observe(4);
    chk("R9 stopped", 32'(seen), 0);
    chk("R9 code kept", 32'(code), 9);
    pd_n = 1'b1;
    tick(3); observe(4);
    chk("R9 resumed", 32'(seen), 32'h1ff_ffff);

    // R8 rapid enable churn under the model
    begin
      logic [NC-1:0] lf = 25'h1_2345;
      for (int j = 0; j < 60; j++) begin
        lf = {lf[NC-2:0], lf[24] ^ lf[21]};
        set_en(lf);
        pd_n = (j % 13) != 5;
        tick(1);
      end
    end
    pd_n = 1'b1;
    tick(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule